// File: doc/BRIEF.md
# Host register port with queued channel interrupts

This block is the host-side register port of a multi-channel device. A processor reaches it over a non-multiplexed asynchronous bus: an 11-bit address, an 8-bit bidirectional data bus, two active-low qualifiers (a select and a strobe), a direction line, and an active-low open-drain completion flag. The bus qualifiers are brought into the block clock domain through two-stage synchronisers. Each access is carried out exactly once, and the completion flag is pulled low a fixed number of clocks later. It stays low until the strobe is withdrawn. Four byte-wide registers can be written and read. The first of them is the main control register, and its bit 6 leaves the block as an output-drive enable.

Thirty-two channel event inputs feed an interrupt queue. Each event records the number of the channel that raised it. The host removes entries by reading one queue register. An open-drain interrupt line is held low while any channel is waiting, and it is released only after the last queued entry has been read. A channel that already has an entry outstanding cannot queue a second one. The queue is therefore never asked to hold more entries than there are channels.

Top module: `hostport_irqq`

## Requirements
- R1: An access takes place only while `hp_sel_n` and `hp_stb_n` are both low. With either of them high, no register changes and `hp_done_n` stays released.
- R2: `hp_done_n` is pulled low on the third rising clock edge after the edge that first samples the access as active. The inputs pass through two synchronising flops, and completion comes two clocks after the synchronised access is seen. The line is released on the third rising edge after the access ends.
- R3: A write (`hp_read`=0) to address 0x000 to 0x003 stores the data byte, and a later read of the same address returns it. The address decode uses all 11 bits.
- R4: The block drives `hp_data` only during a read while `hp_done_n` is low. It drives the byte that was captured when the access completed. At all other times `hp_data` is high impedance.
- R5: `drive_en` equals bit 6 of the register at address 0x000. Reset sets it to 0.
- R6: Reading address 0x010 returns the oldest queued entry and removes it. The word has the valid flag in bit 7, bits 6:5 zero, and the channel number in bits 4:0. When the queue is empty the read returns 0x00 and removes nothing.
- R7: `hp_irq_n` is pulled low from the clock edge that samples a channel event. It is released only when no event is waiting and the queue has been drained.
- R8: A `chan_evt` bit is sampled high on a rising edge. If that channel is already waiting or queued at that edge, the event is dropped. This includes the edge on which its entry is read out.
- R9: When several channels are waiting, one entry is queued per clock, lowest channel number first. Events on different edges are queued in arrival order.
- R10: Writes to address 0x010 and to unmapped addresses change nothing. Reads of unmapped addresses return 0x00.
- R11: After reset, `hp_done_n` and `hp_irq_n` are released, `hp_data` is not driven, and all registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hp_addr | input | 11 | Register address |
| hp_data | inout | 8 | Bidirectional data byte |
| hp_sel_n | input | 1 | Active-low port select |
| hp_stb_n | input | 1 | Active-low data strobe |
| hp_read | input | 1 | Direction: 1 read, 0 write |
| hp_done_n | output | 1 | Open-drain active-low transfer completion |
| hp_irq_n | output | 1 | Open-drain active-low interrupt request |
| chan_evt | input | 32 | Per-channel event inputs, sampled on the clock |
| drive_en | output | 1 | Output-drive enable, bit 6 of control register |

## Verification
The bench raises several events on the same edge and expects them to be read back lowest channel first. A design with the wrong priority, or one that dropped a simultaneous event, would return entries in the wrong order or too few. It repeats an event for a channel that is already queued and expects exactly one entry. It reads the empty queue and expects 0x00 with the interrupt line released, which catches a duplicate entry, an interrupt that clears early, or a stale valid bit. It strobes with only one qualifier low and writes to the queue and unmapped addresses. A port that decoded half an access, or aliased on the upper address bits, would then show a changed register. A per-clock model checks the timing of the completion and interrupt lines. It also checks when the bus is driven, so a flag that completes one clock early or late, or a bus that is driven outside the read window, mismatches on the cycle where it happens.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned HP_AW = 11;
  localparam int unsigned HP_DW = 8;
  localparam logic [HP_AW-1:0] HP_A_QUEUE = 11'h010;
  localparam int unsigned HP_DRV_BIT = 6;
endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/hp_bus_fsm.sv
module hp_bus_fsm #(
  parameter  int unsigned ACK_DLY = 2,
  localparam int unsigned KW      = $clog2(ACK_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic go,
  output logic ack
);
  logic [KW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;

  assign go  = act && !ack_q && (cnt_q == KW'(ACK_DLY - 1));
  assign ack = ack_q;

  always_comb begin
    cnt_d = cnt_q;
    ack_d = ack_q;
    if (!act) begin
      cnt_d = '0;
      ack_d = 1'b0;
    end else if (!ack_q) begin
      cnt_d = cnt_q + 1'b1;
      ack_d = go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ack_q <= ack_d;
    end
  end

  // R2: completion only rises out of a held access
  p_ack_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(act));
  // R2: completion withdrawn once the access ends
  p_ack_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !ack_q);
  // R1: each access acts once
  p_single_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
endmodule

// File: rtl/hp_irq_queue.sv
module hp_irq_queue #(
  parameter  int unsigned NCH   = 32,
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned CHW   = $clog2(NCH),
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           pop_req,
  output logic           head_vld,
  output logic [CHW-1:0] head_chan,
  output logic           busy
);
  logic [NCH-1:0] lat_q, lat_d, inq_q, inq_d;
  logic [CHW-1:0] mem [DEPTH];
  logic [PW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           push, pop;
  logic [CHW-1:0] pidx;

  always_comb begin
    pidx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (lat_q[i]) pidx = CHW'(i);
    end
  end

  assign push      = |lat_q;
  assign head_vld  = (cnt_q != '0);
  assign pop       = pop_req && head_vld;
  assign head_chan = mem[rp_q];
  assign busy      = push || head_vld;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      lat_d[i] = (lat_q[i] && !(push && pidx == CHW'(i))) ||
                 (evt[i] && !lat_q[i] && !inq_q[i]);
      inq_d[i] = (inq_q[i] && !(pop && head_chan == CHW'(i))) ||
                 (push && pidx == CHW'(i));
    end
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      inq_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      lat_q <= lat_d;
      inq_q <= inq_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= pidx;
  end

  // R8: pending map keeps storage within depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  // R8: a channel already queued is never queued again
  p_no_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !inq_q[pidx]);
  // R7: request stays active while entries remain
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pop_req) |=> busy);
endmodule

// File: rtl/hostport_irqq.sv
module hostport_irqq
  import hp_pkg::*;
#(
  parameter int unsigned NCH     = 32,
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned NREG    = 4,
  parameter int unsigned ACK_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HP_AW-1:0] hp_addr,
  inout  wire  [HP_DW-1:0] hp_data,
  input  logic             hp_sel_n,
  input  logic             hp_stb_n,
  input  logic             hp_read,
  output wire              hp_done_n,
  output wire              hp_irq_n,
  input  logic [NCH-1:0]   chan_evt,
  output logic             drive_en
);
  localparam int unsigned CHW = $clog2(NCH);
  localparam int unsigned RIW = (NREG > 1) ? $clog2(NREG) : 1;

  logic             srst_n, act, go, ack, busy, head_vld, pop_req;
  logic [CHW-1:0]   head_chan;
  logic [HP_DW-1:0] reg_q [NREG];
  logic [NREG-1:0]  wr_en;
  logic [HP_DW-1:0] rd_word, rdata_q, rdata_d;
  logic             rd_q, rd_d, oe;

  hp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  hp_sync #(.W(1)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(~hp_sel_n & ~hp_stb_n), .q(act)
  );

  hp_bus_fsm #(.ACK_DLY(ACK_DLY)) u_fsm (
    .clk(clk), .rst_n(srst_n), .act(act), .go(go), .ack(ack)
  );

  hp_irq_queue #(.NCH(NCH), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(srst_n), .evt(chan_evt), .pop_req(pop_req),
    .head_vld(head_vld), .head_chan(head_chan), .busy(busy)
  );

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_wen
      assign wr_en[g] = go && !hp_read && (hp_addr == HP_AW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en[i]) reg_q[i] <= hp_data;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (hp_addr < HP_AW'(NREG)) begin
      rd_word = reg_q[hp_addr[RIW-1:0]];
    end else if (hp_addr == HP_A_QUEUE) begin
      rd_word = head_vld ? {1'b1, {(HP_DW - 1 - CHW){1'b0}}, head_chan} : '0;
    end
  end

  assign pop_req = go && hp_read && (hp_addr == HP_A_QUEUE);

  always_comb begin
    rdata_d = rdata_q;
    rd_d    = rd_q;
    if (go) begin
      rdata_d = rd_word;
      rd_d    = hp_read;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      rd_q    <= rd_d;
    end
  end

  assign oe        = ack && rd_q;
  assign hp_data   = oe ? rdata_q : {HP_DW{1'bz}};
  assign hp_done_n = ack ? 1'b0 : 1'bz;
  assign hp_irq_n  = busy ? 1'b0 : 1'bz;
  assign drive_en  = reg_q[0][HP_DRV_BIT];

  // R4: driven byte does not change while the read is held
  p_read_stable_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (ack && $past(ack)) |-> $stable(rdata_q));
  // R5: control write lands on the drive enable
  p_ctrl_write_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (go && !hp_read && hp_addr == '0) |=> (drive_en == $past(hp_data[HP_DRV_BIT])));
  // R1: no register update without an active access
  p_no_write_idle_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !act |=> $stable(drive_en));
endmodule

// File: tb/sim_hostport_irqq.sv
`timescale 1ns/1ps
module sim_hostport_irqq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  drv = '0;
  logic        drv_en = 1'b0;
  logic        sel_n = 1'b1, stb_n = 1'b1, rd = 1'b1;
  logic [31:0] evt = '0;
  wire  [7:0]  bus;
  wire         done_n, irq_n, drive_en;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign bus = drv_en ? drv : 8'bz;
  pullup (done_n);
  pullup (irq_n);
  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : g_pu
      pullup (bus[gi]);
    end
  endgenerate

  hostport_irqq u0 (
    .clk(clk), .rst_n(rst_n), .hp_addr(addr), .hp_data(bus),
    .hp_sel_n(sel_n), .hp_stb_n(stb_n), .hp_read(rd),
    .hp_done_n(done_n), .hp_irq_n(irq_n), .chan_evt(evt), .drive_en(drive_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act_v, exp_v);
    end
  endtask

  // behavioural reference model
  bit m_s1, m_s2, m_ack, m_rd, m_go;
  int m_cnt, m_pidx;
  logic [7:0] m_rdata;
  logic [7:0] mregs [4];
  bit [31:0] lat, olat, oinq;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ack = 0; m_rd = 0; m_cnt = 0; m_rdata = 0;
      lat = '0; q.delete();
      for (int i = 0; i < 4; i++) mregs[i] = 8'h00;
    end else begin
      olat = lat; oinq = '0;
      foreach (q[k]) oinq[q[k]] = 1'b1;
      m_go = m_s2 && !m_ack && m_cnt == 1;
      if (m_go) begin
        m_rd = rd;
        if (rd) begin
          if (addr < 4) m_rdata = mregs[addr[1:0]];
          else if (addr == 11'h010) begin
            if (q.size() > 0) begin
              m_rdata = 8'h80 | 8'(q[0]);
              void'(q.pop_front());
            end else m_rdata = 8'h00;
          end else m_rdata = 8'h00;
        end else if (addr < 4) mregs[addr[1:0]] = drv;
      end
      if (!m_s2) begin m_cnt = 0; m_ack = 0; end
      else if (!m_ack) begin if (m_cnt == 1) m_ack = 1; m_cnt++; end
      m_s2 = m_s1;
      m_s1 = !sel_n && !stb_n;
      m_pidx = -1;
      for (int i = 31; i >= 0; i--) if (olat[i]) m_pidx = i;
      if (m_pidx >= 0) begin q.push_back(m_pidx); lat[m_pidx] = 1'b0; end
      for (int i = 0; i < 32; i++) if (evt[i] && !olat[i] && !oinq[i]) lat[i] = 1'b1;
    end
    #2;
    chk((done_n === 1'b0) == m_ack, "R2 done timing", {31'd0, done_n}, {31'd0, !m_ack});
    chk((irq_n === 1'b0) == ((lat != 0) || q.size() != 0), "R7 irq level",
        {31'd0, irq_n}, {31'd0, !((lat != 0) || q.size() != 0)});
    chk(drive_en === mregs[0][6], "R5 drive_en", {31'd0, drive_en}, {31'd0, mregs[0][6]});
    if (!drv_en)
      chk(bus === ((m_ack && m_rd) ? m_rdata : 8'hFF), "R4 bus drive", bus,
          (m_ack && m_rd) ? m_rdata : 8'hFF);
  end

  task automatic wait_done(input bit want_low);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if ((done_n === 1'b0) == want_low) return;
    end
    chk(0, "R2 handshake timeout", {31'd0, done_n}, {31'd0, !want_low});
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; drv = d; drv_en = 1; rd = 0; sel_n = 0; stb_n = 0;
    wait_done(1);
    sel_n = 1; stb_n = 1;
    wait_done(0);
    drv_en = 0; rd = 1;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1; sel_n = 0; stb_n = 0;
    wait_done(1);
    d = bus;
    sel_n = 1; stb_n = 1;
    wait_done(0);
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic rd_chk(input logic [10:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    bus_read(a, v);
    chk(v === e, tag, v, e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(done_n === 1'b1, "R11 done released", {31'd0, done_n}, 1);
    chk(irq_n === 1'b1, "R11 irq released", {31'd0, irq_n}, 1);
    chk(bus === 8'hFF, "R11 bus undriven", bus, 8'hFF);
    rd_chk(11'h000, 8'h00, "R11 ctrl reset");
    rd_chk(11'h010, 8'h00, "R11 queue empty");

    // R3 register write/readback
    bus_write(11'h001, 8'h5A);
    bus_write(11'h003, 8'hC3);
    rd_chk(11'h001, 8'h5A, "R3 reg1 readback");
    rd_chk(11'h003, 8'hC3, "R3 reg3 readback");
    // R10 full decode: no aliasing in upper address bits
    rd_chk(11'h401, 8'h00, "R10 unmapped read");
    bus_write(11'h402, 8'h11);
    rd_chk(11'h002, 8'h00, "R10 unmapped write ignored");

    // R5 drive enable from bit 6 of control
    bus_write(11'h000, 8'h40);
    chk(drive_en === 1'b1, "R5 drive_en set", {31'd0, drive_en}, 1);
    bus_write(11'h000, 8'hBF);
    chk(drive_en === 1'b0, "R5 drive_en clear", {31'd0, drive_en}, 0);

    // R1 half-qualified accesses do nothing
    @(negedge clk);
    addr = 11'h001; drv = 8'h77; drv_en = 1; rd = 0; sel_n = 1; stb_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(done_n === 1'b1, "R1 select high no done", {31'd0, done_n}, 1);
    end
    sel_n = 0; stb_n = 1;
    repeat (8) @(negedge clk);
    sel_n = 1; drv_en = 0; rd = 1;
    rd_chk(11'h001, 8'h5A, "R1 register untouched");

    // R9 simultaneous events, lowest channel first; R7 irq
    pulse(32'h0010_0088);
    chk(irq_n === 1'b0, "R7 irq asserted", {31'd0, irq_n}, 0);
    rd_chk(11'h010, 8'h83, "R9 first ch3");
    rd_chk(11'h010, 8'h87, "R9 second ch7");
    chk(irq_n === 1'b0, "R7 irq held while queued", {31'd0, irq_n}, 0);
    rd_chk(11'h010, 8'h94, "R9 third ch20");
    rd_chk(11'h010, 8'h00, "R6 empty after drain");
    chk(irq_n === 1'b1, "R7 irq released after drain", {31'd0, irq_n}, 1);

    // R9 arrival order across edges
    pulse(32'h8000_0000);
    pulse(32'h0000_0001);
    rd_chk(11'h010, 8'h9F, "R9 arrival ch31");
    rd_chk(11'h010, 8'h80, "R9 arrival ch0");

    // R8 duplicate dropped
    pulse(32'h0000_0020);
    repeat (3) @(negedge clk);
    pulse(32'h0000_0020);
    rd_chk(11'h010, 8'h85, "R8 single entry ch5");
    rd_chk(11'h010, 8'h00, "R8 no duplicate");

    // R10 writes to queue register ignored
    pulse(32'h0000_0200);
    bus_write(11'h010, 8'hFF);
    rd_chk(11'h010, 8'h89, "R10 queue write ignored");
    rd_chk(11'h010, 8'h00, "R6 empty read valid clear");

    // R8 event in the cycle of readout is dropped, others kept
    pulse(32'h0000_0004);
    @(negedge clk);
    addr = 11'h010; rd = 1; sel_n = 0; stb_n = 0;
    repeat (2) @(negedge clk);
    evt = 32'h0000_0004;
    @(negedge clk);
    evt = '0;
    wait_done(1);
    sel_n = 1; stb_n = 1;
    wait_done(0);
    repeat (4) @(negedge clk);
    chk((irq_n === 1'b0) == ((lat != 0) || q.size() != 0), "R8 readout-cycle event",
        {31'd0, irq_n}, {31'd0, !((lat != 0) || q.size() != 0)});
    for (int i = 0; i < 2; i++) begin
      logic [7:0] v;
      bus_read(11'h010, v);
    end
    rd_chk(11'h010, 8'h00, "R6 final drain");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule